// File: doc/BRIEF.md
# Dual-Bank Phase Accumulator Oscillator

This block is the phase engine of a direct digital synthesizer. Every clock it adds a tuning word to a wide phase accumulator. It takes the top bits of that accumulator, adds a phase offset to them, and presents the truncated result as the phase of the output waveform. A waveform stage placed downstream turns that phase into amplitude. The output frequency equals the tuning word times the clock frequency divided by 2^ACC_W. The offset has a resolution of one full turn divided by 2^PH_W.

The block holds two tuning words and two offsets side by side, and a select bit for each pair chooses the active word. Frequency-shift keying or phase-shift keying is done by toggling a select bit. Moving between tuning words changes only the step size, never the accumulated phase, so the output phase stays continuous. A clear input holds the accumulator and the pipeline at zero. A halt input freezes the pipeline while the word and select inputs are still captured. A valid flag marks the output phase once the pipeline has filled after a clear. LATENCY must be at least 3.

Top module: `nco_phase_core`

## Requirements
- R1: On every cycle that is not cleared or halted, the accumulator adds the selected tuning word, modulo 2^ACC_W. A tuning word of 28'hFFF0000 therefore lowers the output phase by one LSB (12'hFFF modulo 4096) per cycle.
- R2: A select value of 0 on `fsel_i` selects `freq0_i` and a value of 1 selects `freq1_i`. All word and select inputs are registered once before they are used.
- R3: `phase_o` equals the top PH_W bits of the accumulator plus the selected offset, modulo 2^PH_W. `psel_i` = 0 selects `phase0_i` and `psel_i` = 1 selects `phase1_i`.
- R4: Changing `fsel_i` never resets the accumulator and never makes it jump. The step between successive outputs is always one of the two tuning words.
- R5: While `clear_i` is registered high, the accumulator and every pipeline stage are zero, so `phase_o` = 0 and `valid_o` = 0.
- R6: From the second edge after `halt_i` is sampled high, `phase_o` and `valid_o` hold their values for as long as halt stays high. Changes to the inputs made during the halt appear in the output after the halt is released.
- R7: Suppose `clear_i` is first sampled low on edge E0. Then `valid_o` rises on edge E0+LATENCY, and the phase output is delayed by the same pipeline.
- R8: While the synchronous reset `rst` is high, `phase_o` = 0 and `valid_o` = 0. On release, the block behaves as if `clear_i` had been high.
- R9: `clear_i` takes priority over `halt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freq0_i | input | ACC_W | Tuning word, bank 0 |
| freq1_i | input | ACC_W | Tuning word, bank 1 |
| phase0_i | input | PH_W | Phase offset, bank 0 |
| phase1_i | input | PH_W | Phase offset, bank 1 |
| fsel_i | input | 1 | Tuning word bank select |
| psel_i | input | 1 | Phase offset bank select |
| clear_i | input | 1 | Hold accumulator and pipeline at zero |
| halt_i | input | 1 | Freeze accumulation and output |
| phase_o | output | PH_W | Truncated output phase |
| valid_o | output | 1 | Output phase is meaningful |

## Verification
The bench targets the following corners, each paired with the error it would expose:
- Tuning-word wrap near 2^28. A design that lost the carry would step the phase by the wrong amount.
- Offset wrap past 4096. A design that saturated instead of wrapping would give a wrong phase difference between the two offset banks.
- Switching the tuning-word bank while running. A design that reloaded or cleared the accumulator on the switch would show a phase step that matches neither tuning word.
- The fill time after a clear. Misplaced valid staging would move the valid edge by one or more cycles.
- Halt while the inputs change. A design that let the pipeline drain, or that dropped the captured inputs, would move the output during the halt.
- Clear that overlaps halt. This is exercised inside a long seeded random run that is compared cycle by cycle.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int NCO_ACC_W   = 28;
  localparam int NCO_PH_W    = 12;
  localparam int NCO_LATENCY = 7;

  typedef enum logic {BANK0 = 1'b0, BANK1 = 1'b1} bank_e;
endpackage

// File: rtl/nco_sel_reg.sv
module nco_sel_reg
  import nco_pkg::*;
#(
  parameter int ACC_W = NCO_ACC_W,
  parameter int PH_W  = NCO_PH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freq0_i,
  input  logic [ACC_W-1:0] freq1_i,
  input  logic [PH_W-1:0]  phase0_i,
  input  logic [PH_W-1:0]  phase1_i,
  input  logic             fsel_i,
  input  logic             psel_i,
  input  logic             clear_i,
  input  logic             halt_i,
  output logic [ACC_W-1:0] tw_o,
  output logic [PH_W-1:0]  off_o,
  output logic             clear_o,
  output logic             halt_o
);
  bank_e fbank, pbank;
  assign fbank = bank_e'(fsel_i);
  assign pbank = bank_e'(psel_i);

  // Inputs are captured every cycle, including during halt.
  always_ff @(posedge clk) begin
    if (rst) begin
      tw_o    <= '0;
      off_o   <= '0;
      clear_o <= 1'b1;
      halt_o  <= 1'b0;
    end else begin
      tw_o    <= (fbank == BANK1) ? freq1_i : freq0_i;
      off_o   <= (pbank == BANK1) ? phase1_i : phase0_i;
      clear_o <= clear_i;
      halt_o  <= halt_i;
    end
  end

  a_r8_reset_clears : assert property (@(posedge clk) rst |=> clear_o && !halt_o)
    else $error("reset did not force the clear state");
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
#(
  parameter int ACC_W = NCO_ACC_W,
  parameter int PH_W  = NCO_PH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tw_i,
  input  logic [PH_W-1:0]  off_i,
  input  logic             clear_i,
  input  logic             halt_i,
  output logic [PH_W-1:0]  top_o,
  output logic [PH_W-1:0]  off_o,
  output logic             vld_o
);
  localparam int TOP_LSB = ACC_W - PH_W;

  logic [ACC_W-1:0] acc;

  // The tuning word only sets the step; the accumulator is never reloaded.
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      acc   <= '0;
      off_o <= '0;
      vld_o <= 1'b0;
    end else if (!halt_i) begin
      acc   <= acc + tw_i;
      off_o <= off_i;
      vld_o <= 1'b1;
    end
  end

  assign top_o = acc[ACC_W-1:TOP_LSB];

  a_r5_clear_zero : assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (acc == '0) && !vld_o)
    else $error("accumulator not zero under clear");

  a_r1_step : assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !halt_i) |=> acc == ACC_W'($past(acc) + $past(tw_i)))
    else $error("accumulator step differs from tuning word");

  a_r6_acc_hold : assert property (@(posedge clk) disable iff (rst)
    (halt_i && !clear_i) |=> $stable(acc))
    else $error("accumulator moved during halt");
endmodule

// File: rtl/nco_offset_add.sv
module nco_offset_add
  import nco_pkg::*;
#(
  parameter int PH_W = NCO_PH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] top_i,
  input  logic [PH_W-1:0] off_i,
  input  logic            vld_i,
  input  logic            clear_i,
  input  logic            halt_i,
  output logic [PH_W-1:0] sum_o,
  output logic            vld_o
);
  // Modulo 2^PH_W add: the carry out is dropped on purpose.
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      sum_o <= '0;
      vld_o <= 1'b0;
    end else if (!halt_i) begin
      sum_o <= top_i + off_i;
      vld_o <= vld_i;
    end
  end

  a_r3_offset_sum : assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !halt_i) |=> sum_o == PH_W'($past(top_i) + $past(off_i)))
    else $error("offset sum wrong");
endmodule

// File: rtl/nco_delay_line.sv
module nco_delay_line #(
  parameter int W     = 13,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         halt_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] src;
    if (i == 0) begin : g_head
      assign src = d_i;
    end else begin : g_body
      assign src = stg[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clear_i)  stg[i] <= '0;
      else if (!halt_i)    stg[i] <= src;
    end
  end

  assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int ACC_W   = NCO_ACC_W,
  parameter int PH_W    = NCO_PH_W,
  parameter int LATENCY = NCO_LATENCY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freq0_i,
  input  logic [ACC_W-1:0] freq1_i,
  input  logic [PH_W-1:0]  phase0_i,
  input  logic [PH_W-1:0]  phase1_i,
  input  logic             fsel_i,
  input  logic             psel_i,
  input  logic             clear_i,
  input  logic             halt_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             valid_o
);
  localparam int DLY   = LATENCY - 2;
  localparam int TAP_W = PH_W + 1;

  logic [ACC_W-1:0] tw_q;
  logic [PH_W-1:0]  off_q, off_d, top, sum;
  logic             clear_q, halt_q, acc_vld, sum_vld;
  logic [TAP_W-1:0] tap;

  nco_sel_reg #(.ACC_W(ACC_W), .PH_W(PH_W)) u_sel (
    .clk(clk), .rst(rst),
    .freq0_i(freq0_i), .freq1_i(freq1_i),
    .phase0_i(phase0_i), .phase1_i(phase1_i),
    .fsel_i(fsel_i), .psel_i(psel_i),
    .clear_i(clear_i), .halt_i(halt_i),
    .tw_o(tw_q), .off_o(off_q), .clear_o(clear_q), .halt_o(halt_q)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst(rst), .tw_i(tw_q), .off_i(off_q),
    .clear_i(clear_q), .halt_i(halt_q),
    .top_o(top), .off_o(off_d), .vld_o(acc_vld)
  );

  nco_offset_add #(.PH_W(PH_W)) u_add (
    .clk(clk), .rst(rst), .top_i(top), .off_i(off_d), .vld_i(acc_vld),
    .clear_i(clear_q), .halt_i(halt_q),
    .sum_o(sum), .vld_o(sum_vld)
  );

  nco_delay_line #(.W(TAP_W), .DEPTH(DLY)) u_dly (
    .clk(clk), .rst(rst), .clear_i(clear_q), .halt_i(halt_q),
    .d_i({sum_vld, sum}), .q_o(tap)
  );

  assign phase_o = tap[PH_W-1:0];
  assign valid_o = tap[PH_W];

  a_r6_out_hold : assert property (@(posedge clk) disable iff (rst)
    (halt_q && !clear_q) |=> $stable(phase_o) && $stable(valid_o))
    else $error("output moved during halt");

  a_r9_clear_wins : assert property (@(posedge clk) disable iff (rst)
    (clear_q && halt_q) |=> !valid_o && (phase_o == '0))
    else $error("halt overrode clear");

  a_r8_reset_out : assert property (@(posedge clk)
    rst |=> !valid_o && (phase_o == '0))
    else $error("reset did not zero the output");
endmodule

// File: tb/tb_nco_phase_core.sv
module tb_nco_phase_core;
  localparam int AW  = 28;
  localparam int PW  = 12;
  localparam int LAT = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] freq0 = '0, freq1 = '0;
  logic [PW-1:0] ph0 = '0, ph1 = '0;
  logic fsel = 1'b0, psel = 1'b0, clr = 1'b1, halt = 1'b0;
  logic [PW-1:0] phase_o;
  logic valid_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nco_phase_core #(.ACC_W(AW), .PH_W(PW), .LATENCY(LAT)) dut (
    .clk(clk), .rst(rst), .freq0_i(freq0), .freq1_i(freq1),
    .phase0_i(ph0), .phase1_i(ph1), .fsel_i(fsel), .psel_i(psel),
    .clear_i(clr), .halt_i(halt), .phase_o(phase_o), .valid_o(valid_o)
  );

  // Reference model built from the requirements.
  logic [AW-1:0] m_tw, m_acc;
  logic [PW-1:0] m_off, m_offd;
  logic m_clr, m_halt, m_accv;
  logic [PW:0] m_pipe [LAT-1];

  function automatic logic [PW:0] sum_tap(logic v, logic [AW-1:0] a, logic [PW-1:0] o);
    logic [PW-1:0] s;
    s = a[AW-1:AW-PW] + o;
    return {v, s};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_tw <= '0; m_off <= '0; m_clr <= 1'b1; m_halt <= 1'b0;
      m_acc <= '0; m_offd <= '0; m_accv <= 1'b0;
      for (int i = 0; i < LAT-1; i++) m_pipe[i] <= '0;
    end else begin
      m_tw   <= fsel ? freq1 : freq0;
      m_off  <= psel ? ph1 : ph0;
      m_clr  <= clr;
      m_halt <= halt;
      if (m_clr) begin
        m_acc <= '0; m_offd <= '0; m_accv <= 1'b0;
        for (int i = 0; i < LAT-1; i++) m_pipe[i] <= '0;
      end else if (!m_halt) begin
        m_acc  <= m_acc + m_tw;
        m_offd <= m_off;
        m_accv <= 1'b1;
        m_pipe[0] <= sum_tap(m_accv, m_acc, m_offd);
        for (int i = 1; i < LAT-1; i++) m_pipe[i] <= m_pipe[i-1];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R1 R2 R3 R7).
  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      check(phase_o == m_pipe[LAT-2][PW-1:0], "R1 R2 R3 phase stream",
            int'(phase_o), int'(m_pipe[LAT-2][PW-1:0]));
      check(valid_o == m_pipe[LAT-2][PW], "R7 valid stream",
            int'(valid_o), int'(m_pipe[LAT-2][PW]));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [PW-1:0] a, b;
    int n;
    void'($urandom(32'd20240607));
    cyc(4);
    // R8: reset state
    check(phase_o == '0 && valid_o == 1'b0, "R8 reset state", int'({valid_o, phase_o}), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    cyc(4);
    // R5: clear held
    check(phase_o == '0 && valid_o == 1'b0, "R5 clear holds zero", int'({valid_o, phase_o}), 0);

    // R7: latency from clear release
    freq0 = AW'(1) << (AW-PW);
    clr = 1'b0;
    n = 0;
    do begin cyc(1); n++; end while (!valid_o && n < 40);
    check(n == LAT + 1, "R7 valid latency (negedges after release)", n, LAT + 1);

    // R2 / R4: bank switch keeps continuity
    cyc(1); a = phase_o; cyc(1); b = phase_o;
    check(PW'(b - a) == 12'd1, "R2 bank0 step", int'(PW'(b - a)), 1);
    freq1 = AW'(3) << (AW-PW);
    fsel = 1'b1;
    a = phase_o;
    for (int k = 0; k < 12; k++) begin
      cyc(1); b = phase_o;
      check(PW'(b - a) == 12'd1 || PW'(b - a) == 12'd3, "R4 continuous step",
            int'(PW'(b - a)), 3);
      a = b;
    end
    cyc(1); b = phase_o;
    check(PW'(b - a) == 12'd3, "R2 bank1 step", int'(PW'(b - a)), 3);

    // R3: offset banks with a frozen accumulator, wrap mod 4096
    fsel = 1'b0; freq0 = '0; ph0 = 12'd5; ph1 = 12'hFFE; psel = 1'b0;
    cyc(LAT + 3); a = phase_o;
    psel = 1'b1;
    cyc(LAT + 3); b = phase_o;
    check(PW'(b - a) == 12'hFF9, "R3 offset wrap", int'(PW'(b - a)), 'hFF9);

    // R1: near-full tuning word wraps the accumulator
    psel = 1'b0; freq0 = 28'hFFF0000;
    cyc(LAT + 3); a = phase_o; cyc(1); b = phase_o;
    check(PW'(b - a) == 12'hFFF, "R1 accumulator wrap", int'(PW'(b - a)), 'hFFF);

    // R6: halt freezes output while inputs change
    halt = 1'b1;
    cyc(2); a = phase_o;
    for (int k = 0; k < 6; k++) begin
      freq0 = AW'($urandom); psel = ~psel; fsel = ~fsel;
      cyc(1);
      check(phase_o == a && valid_o, "R6 output held in halt", int'(phase_o), int'(a));
    end
    halt = 1'b0;
    cyc(LAT + 2);

    // R9: clear during halt
    halt = 1'b1; clr = 1'b1;
    cyc(3);
    check(phase_o == '0 && !valid_o, "R9 clear over halt", int'({valid_o, phase_o}), 0);
    halt = 1'b0; clr = 1'b0;

    // Seeded random run checked by the model
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      freq0 = AW'($urandom); freq1 = AW'($urandom);
      ph0 = PW'($urandom); ph1 = PW'($urandom);
      if (($urandom % 4) == 0) fsel = ~fsel;
      if (($urandom % 4) == 0) psel = ~psel;
      clr  = (($urandom % 64) == 0);
      halt = (($urandom % 8) == 0);
    end
    clr = 1'b0; halt = 1'b0;
    cyc(LAT + 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule